// File: doc/BRIEF.md
# Soft-Start and Hiccup Fault Sequencer

This block sequences the start-up and fault recovery of a dual-output supply made of a switching regulator and a linear regulator that share one reference. It holds both outputs off until two bias-supply power-good inputs are both high, in any order. It then brings up a shared reference code through a DAC interface. Each ramp starts with a short initialisation phase at code zero. After that the code climbs by one step per slow tick until it reaches the regulation code. Both regulators track that code.

Two undervoltage comparator results and an external shutdown comparator result arrive as asynchronous digital inputs. An undervoltage on either output, once checking is armed, turns both outputs off at once. The block then runs a hiccup retry: a fixed number of internal dummy ramps with the outputs held off, followed by a real ramp. The retry repeats without limit for as long as the fault comes back. Holding the shutdown input high keeps everything off, and releasing it starts a fresh ramp. The slow tick is a synchronous enable divided from the system clock, so the block runs in a single clock domain.

Top module: `ss_hiccup_seq`

## Requirements
- R1: After reset all outputs are 0. `reg_en_o` rises on the third rising clock edge after both power-good inputs are high, whichever of them rises last. While either one is low, the outputs stay off.
- R2: Every ramp, real or dummy, begins with INIT_TICKS ticks at code 0. TICK_DIV system clocks make one tick.
- R3: In a real ramp `ref_code_o` rises by exactly 1 every TICK_DIV clocks after the initialisation ticks. It stops at STEP_COUNT and holds there. The code changes only on a tick.
- R4: `ss_done_o` rises on the same edge that `ref_code_o` reaches STEP_COUNT. It clears on shutdown, on an undervoltage fault and on power-good loss.
- R5: A synchronised undervoltage input counts only if it is high for two consecutive clocks. A one-clock pulse has no effect.
- R6: An armed undervoltage on either output forces `reg_en_o`=0, `ref_code_o`=0, `ss_done_o`=0 and `fault_o`=1 on the fourth edge after the input rises.
- R7: Undervoltage is armed only during a real ramp with code at least ARM_STEP, and during regulation. It is ignored during initialisation, below ARM_STEP and in dummy ramps. A held undervoltage faults one edge after the code reaches ARM_STEP.
- R8: After a fault, `reg_en_o` returns and `fault_o` clears exactly HICCUP_RAMPS*(INIT_TICKS+STEP_COUNT)*TICK_DIV clocks after `fault_o` rose. The new ramp is a normal ramp.
- R9: If the undervoltage is still present once the retried ramp is armed, the hiccup repeats, with no limit on retries.
- R10: A high shutdown input turns the outputs off on the third edge and clears `fault_o`, including during a hiccup. Releasing it starts a real ramp on the third edge after release.
- R11: Loss of either power-good input returns the block to idle, with all outputs 0, on the third edge, from any state including a hiccup.
- R12: Priority is power-good loss, then shutdown, then undervoltage. Shutdown and undervoltage in the same cycle give no fault. Power-good returning while shutdown is held keeps the outputs off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_ok_a_i | input | 1 | First bias-supply power-good, asynchronous |
| pwr_ok_b_i | input | 1 | Second bias-supply power-good, asynchronous |
| uv_sw_i | input | 1 | Undervoltage comparator, switching output, asynchronous |
| uv_lin_i | input | 1 | Undervoltage comparator, linear output, asynchronous |
| shdn_i | input | 1 | External shutdown comparator, asynchronous |
| ref_code_o | output | CODE_W | Reference DAC code |
| reg_en_o | output | 1 | Enable for both regulators |
| ss_done_o | output | 1 | Ramp complete, in regulation |
| fault_o | output | 1 | Undervoltage hiccup in progress |

## Verification
An armed undervoltage fault and a shutdown request can reach the sequencer's decision logic in the same clock. The bench provokes this by raising the undervoltage input one clock before the shutdown input, so that the persistence filter and the shorter shutdown path both mature on the same edge. It judges the result by checking that the outputs drop on that edge with `fault_o` low, and that releasing shutdown later starts a normal ramp with no hiccup. A power-good drop taken together with shutdown is handled the same way, with the block required to stay off after power-good returns until shutdown is released.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_RAMP,
    ST_RUN,
    ST_SHDN
  } seq_state_e;
endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/ss_tick_gen.sv
module ss_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (cnt_q == LAST)     cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/ss_uv_filter.sv
module ss_uv_filter #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] uv_i,
  output logic         uv_o
);
  logic [N-1:0] hist_q;
  logic [N-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= uv_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_ch
    assign hit[g] = uv_i[g] & hist_q[g];
  end

  assign uv_o = |hit;
endmodule

// File: rtl/ss_ramp_fsm.sv
module ss_ramp_fsm
  import ss_seq_pkg::*;
#(
  parameter int INIT_TICKS   = 3,
  parameter int STEP_COUNT   = 27,
  parameter int ARM_STEP     = 14,
  parameter int HICCUP_RAMPS = 3,
  parameter int CODE_W       = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              por_ok_i,
  input  logic              shdn_i,
  input  logic              uv_i,
  output logic              restart_o,
  output logic [CODE_W-1:0] code_o,
  output logic              en_o,
  output logic              done_o,
  output logic              fault_o
);
  localparam int IW = (INIT_TICKS > 1) ? $clog2(INIT_TICKS) : 1;
  localparam int HW = (HICCUP_RAMPS > 0) ? $clog2(HICCUP_RAMPS + 1) : 1;
  localparam logic [IW-1:0]     INIT_LAST = IW'(INIT_TICKS - 1);
  localparam logic [CODE_W-1:0] CODE_LAST = CODE_W'(STEP_COUNT - 1);
  localparam logic [CODE_W-1:0] CODE_FULL = CODE_W'(STEP_COUNT);
  localparam logic [CODE_W-1:0] CODE_ARM  = CODE_W'(ARM_STEP);
  localparam logic [HW-1:0]     HIC_INIT  = HW'(HICCUP_RAMPS);
  localparam logic              NO_HIC    = (HICCUP_RAMPS == 0);

  seq_state_e        state_q, state_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [IW-1:0]     init_q, init_d;
  logic [HW-1:0]     hic_q, hic_d;
  logic              en_q, en_d, done_q, done_d, fault_q, fault_d;
  logic              armed, restart;

  assign armed = en_q && ((state_q == ST_RUN) ||
                          (state_q == ST_RAMP && code_q >= CODE_ARM));

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    init_d  = init_q;
    hic_d   = hic_q;
    en_d    = en_q;
    done_d  = done_q;
    fault_d = fault_q;
    restart = 1'b0;
    if (!por_ok_i || shdn_i) begin
      state_d = por_ok_i ? ST_SHDN : ST_IDLE;
      code_d  = '0;
      init_d  = '0;
      hic_d   = '0;
      en_d    = 1'b0;
      done_d  = 1'b0;
      fault_d = 1'b0;
    end else if (uv_i && armed) begin
      state_d = ST_INIT;
      restart = 1'b1;
      code_d  = '0;
      init_d  = '0;
      hic_d   = HIC_INIT;
      en_d    = NO_HIC;
      done_d  = 1'b0;
      fault_d = !NO_HIC;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_SHDN: begin
          state_d = ST_INIT;
          restart = 1'b1;
          code_d  = '0;
          init_d  = '0;
          hic_d   = '0;
          en_d    = 1'b1;
          done_d  = 1'b0;
          fault_d = 1'b0;
        end
        ST_INIT: begin
          if (tick_i) begin
            if (init_q == INIT_LAST) begin
              state_d = ST_RAMP;
              init_d  = '0;
            end else begin
              init_d = init_q + 1'b1;
            end
          end
        end
        ST_RAMP: begin
          if (tick_i) begin
            if (code_q == CODE_LAST) begin
              if (hic_q != '0) begin
                // dummy ramp finished: start the next one
                state_d = ST_INIT;
                restart = 1'b1;
                code_d  = '0;
                hic_d   = hic_q - 1'b1;
                en_d    = (hic_q == HW'(1));
                fault_d = (hic_q != HW'(1));
              end else begin
                state_d = ST_RUN;
                code_d  = CODE_FULL;
                done_d  = 1'b1;
              end
            end else begin
              code_d = code_q + 1'b1;
            end
          end
        end
        ST_RUN: ;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      init_q  <= '0;
      hic_q   <= '0;
      en_q    <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      init_q  <= init_d;
      hic_q   <= hic_d;
      en_q    <= en_d;
      done_q  <= done_d;
      fault_q <= fault_d;
    end
  end

  assign restart_o = restart;
  assign code_o    = en_q ? code_q : '0;
  assign en_o      = en_q;
  assign done_o    = done_q;
  assign fault_o   = fault_q;
endmodule

// File: rtl/ss_hiccup_seq.sv
module ss_hiccup_seq #(
  parameter int TICK_DIV     = 5405,
  parameter int INIT_TICKS   = 3,
  parameter int STEP_COUNT   = 27,
  parameter int ARM_STEP     = 14,
  parameter int HICCUP_RAMPS = 3,
  parameter int CODE_W       = $clog2(STEP_COUNT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_a_i,
  input  logic              pwr_ok_b_i,
  input  logic              uv_sw_i,
  input  logic              uv_lin_i,
  input  logic              shdn_i,
  output logic [CODE_W-1:0] ref_code_o,
  output logic              reg_en_o,
  output logic              ss_done_o,
  output logic              fault_o
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] raw, synced;
  logic             por_ok, shdn_s, uv_hit, tick, restart;

  assign raw = {pwr_ok_a_i, pwr_ok_b_i, shdn_i, uv_lin_i, uv_sw_i};

  ss_sync #(.WIDTH(NSYNC)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (synced)
  );

  assign por_ok = synced[4] & synced[3];
  assign shdn_s = synced[2];

  ss_uv_filter #(.N(2)) i_uv_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .uv_i   (synced[1:0]),
    .uv_o   (uv_hit)
  );

  ss_tick_gen #(.DIV(TICK_DIV)) i_tick_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .tick_o    (tick)
  );

  ss_ramp_fsm #(
    .INIT_TICKS   (INIT_TICKS),
    .STEP_COUNT   (STEP_COUNT),
    .ARM_STEP     (ARM_STEP),
    .HICCUP_RAMPS (HICCUP_RAMPS),
    .CODE_W       (CODE_W)
  ) i_ramp_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .por_ok_i  (por_ok),
    .shdn_i    (shdn_s),
    .uv_i      (uv_hit),
    .restart_o (restart),
    .code_o    (ref_code_o),
    .en_o      (reg_en_o),
    .done_o    (ss_done_o),
    .fault_o   (fault_o)
  );
endmodule

// File: rtl/ss_hiccup_seq_chk.sv
module ss_hiccup_seq_chk #(
  parameter int STEP_COUNT = 27,
  parameter int CODE_W     = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_ok,
  input logic              shdn_s,
  input logic              tick,
  input logic [CODE_W-1:0] ref_code_o,
  input logic              reg_en_o,
  input logic              ss_done_o,
  input logic              fault_o
);
  localparam logic [CODE_W-1:0] FULL = CODE_W'(STEP_COUNT);

  AST_DONE_AT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_done_o |-> (reg_en_o && ref_code_o == FULL)); // R4

  AST_CODE_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en_o && $past(reg_en_o)) |->
      (ref_code_o == $past(ref_code_o) || ref_code_o == $past(ref_code_o) + 1'b1)); // R3

  AST_STEP_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en_o && $past(reg_en_o) && ref_code_o != $past(ref_code_o)) |-> $past(tick)); // R3

  AST_FAULT_OUTPUTS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!reg_en_o && ref_code_o == '0 && !ss_done_o)); // R6

  AST_SHDN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_s |=> (!reg_en_o && !fault_o && !ss_done_o)); // R10

  AST_POR_LOSS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_ok |=> (!reg_en_o && !fault_o && !ss_done_o && ref_code_o == '0)); // R11
endmodule

bind ss_hiccup_seq ss_hiccup_seq_chk #(
  .STEP_COUNT (STEP_COUNT),
  .CODE_W     (CODE_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .por_ok     (por_ok),
  .shdn_s     (shdn_s),
  .tick       (tick),
  .ref_code_o (ref_code_o),
  .reg_en_o   (reg_en_o),
  .ss_done_o  (ss_done_o),
  .fault_o    (fault_o)
);

// File: tb/test_ss_hiccup_seq.sv
module test_ss_hiccup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int D   = 4;
  localparam int I   = 2;
  localparam int S   = 6;
  localparam int ARM = 3;
  localparam int H   = 3;
  localparam int CW  = $clog2(S + 1);
  localparam int RAMP_LEN = (I + S) * D;
  localparam int HIC_LEN  = H * RAMP_LEN;
  localparam int ARM_T    = (I + ARM) * D + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_a = 1'b0, pwr_b = 1'b0, uv_sw = 1'b0, uv_lin = 1'b0, shdn = 1'b0;
  logic [CW-1:0] code;
  logic en, done, fault;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ss_hiccup_seq #(
    .TICK_DIV (D), .INIT_TICKS (I), .STEP_COUNT (S),
    .ARM_STEP (ARM), .HICCUP_RAMPS (H)
  ) i_ss_hiccup_seq (
    .clk_i (clk), .rst_ni (rst_n),
    .pwr_ok_a_i (pwr_a), .pwr_ok_b_i (pwr_b),
    .uv_sw_i (uv_sw), .uv_lin_i (uv_lin), .shdn_i (shdn),
    .ref_code_o (code), .reg_en_o (en), .ss_done_o (done), .fault_o (fault)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called on the negedge right after the ramp-entry edge
  task automatic check_ramp();
    for (int t = 0; t <= RAMP_LEN + 3; t++) begin
      int m;
      m = t / D - I;
      chk(t < I * D ? "R2 init code" : "R3 ramp code", int'(code),
          m < 0 ? 0 : (m > S ? S : m));
      chk("R4 done", int'(done), (m >= S) ? 1 : 0);
      chk("R2 enable in ramp", int'(en), 1);
      if (t < RAMP_LEN + 3) cyc(1);
    end
  endtask

  // counts negedges until en is high; optional UV injection in dummy ramps
  task automatic wait_en(input bit inject, output int k, output bit bad);
    k = 0;
    bad = 1'b0;
    while (k < 2000) begin
      cyc(1);
      k++;
      if (inject && k == 10) uv_lin = 1'b1;
      if (inject && k == 30) uv_lin = 1'b0;
      if (en) break;
      if (!fault || code != '0) bad = 1'b1;
    end
  endtask

  task automatic wait_fault(output int k);
    k = 0;
    while (k < 2000) begin
      cyc(1);
      k++;
      if (fault) break;
    end
  endtask

  task automatic uv_two(input bit which);
    if (which) uv_lin = 1'b1; else uv_sw = 1'b1;
    cyc(2);
    uv_lin = 1'b0;
    uv_sw = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k;
    bit bad;
    cyc(3);
    chk("R1 reset code", int'(code), 0);
    chk("R1 reset enable", int'(en), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset fault", int'(fault), 0);
    rst_n = 1'b1;
    cyc(2);

    // R1: one power-good alone, then the other
    pwr_b = 1'b1;
    cyc(10);
    chk("R1 single power-good", int'(en), 0);
    pwr_a = 1'b1;
    cyc(2);
    chk("R1 before third edge", int'(en), 0);
    cyc(1);
    chk("R1 third edge", int'(en), 1);
    check_ramp();

    // R5: one-clock glitch ignored
    uv_sw = 1'b1;
    cyc(1);
    uv_sw = 1'b0;
    cyc(6);
    chk("R5 glitch fault", int'(fault), 0);
    chk("R5 glitch done", int'(done), 1);
    chk("R5 glitch code", int'(code), S);

    // R6: two-clock UV in regulation
    uv_two(1'b0);
    cyc(1);
    chk("R6 fault not before 4th edge", int'(fault), 0);
    cyc(1);
    chk("R6 fault", int'(fault), 1);
    chk("R6 enable off", int'(en), 0);
    chk("R6 code zero", int'(code), 0);
    chk("R4 done cleared by fault", int'(done), 0);

    // R8 hiccup length, R7 UV ignored in dummy ramps
    wait_en(1'b1, k, bad);
    chk("R8 hiccup length", k, HIC_LEN);
    chk("R7 dummy ramps outputs off", int'(bad), 0);
    chk("R8 fault cleared", int'(fault), 0);

    // R7 arming point with UV held from ramp start
    uv_sw = 1'b1;
    wait_fault(k);
    chk("R7 arm point", k, ARM_T);
    // R9 retry repeats
    wait_en(1'b0, k, bad);
    chk("R9 second hiccup length", k, HIC_LEN);
    wait_fault(k);
    chk("R9 fault again", k, ARM_T);
    uv_sw = 1'b0;
    wait_en(1'b0, k, bad);
    chk("R8 third hiccup length", k, HIC_LEN);
    check_ramp();

    // R10 shutdown in regulation
    shdn = 1'b1;
    cyc(2);
    chk("R10 before third edge", int'(en), 1);
    cyc(1);
    chk("R10 shutdown enable", int'(en), 0);
    chk("R10 shutdown code", int'(code), 0);
    chk("R4 done cleared by shutdown", int'(done), 0);
    cyc(20);
    chk("R10 held off", int'(en), 0);
    shdn = 1'b0;
    cyc(3);
    chk("R10 release restart", int'(en), 1);
    check_ramp();

    // R12 UV and shutdown mature on the same edge
    uv_sw = 1'b1;
    cyc(1);
    shdn = 1'b1;
    cyc(3);
    chk("R12 shutdown wins enable", int'(en), 0);
    chk("R12 shutdown wins fault", int'(fault), 0);
    cyc(1);
    chk("R12 no late fault", int'(fault), 0);
    uv_sw = 1'b0;
    cyc(4);
    shdn = 1'b0;
    cyc(3);
    chk("R12 normal restart", int'(en), 1);
    chk("R12 no fault after restart", int'(fault), 0);
    check_ramp();

    // R10 shutdown during hiccup
    uv_two(1'b1);
    cyc(2);
    chk("R6 linear-side fault", int'(fault), 1);
    cyc(10);
    shdn = 1'b1;
    cyc(3);
    chk("R10 shutdown clears fault", int'(fault), 0);
    cyc(2);
    shdn = 1'b0;
    cyc(3);
    chk("R10 release after hiccup", int'(en), 1);
    check_ramp();

    // R11 power-good loss during hiccup
    uv_two(1'b0);
    cyc(2);
    chk("R6 fault before power loss", int'(fault), 1);
    cyc(10);
    pwr_b = 1'b0;
    cyc(2);
    chk("R11 fault before third edge", int'(fault), 1);
    cyc(1);
    chk("R11 idle fault", int'(fault), 0);
    chk("R11 idle enable", int'(en), 0);
    pwr_b = 1'b1;
    cyc(3);
    chk("R1 power-good return", int'(en), 1);
    cyc(10);
    pwr_a = 1'b0;
    cyc(3);
    chk("R11 ramp abort enable", int'(en), 0);
    chk("R11 ramp abort code", int'(code), 0);
    chk("R11 ramp abort done", int'(done), 0);

    // R12 power-good loss with shutdown, return while shutdown held
    pwr_a = 1'b1;
    cyc(3);
    check_ramp();
    pwr_a = 1'b0;
    shdn = 1'b1;
    cyc(3);
    chk("R12 power loss and shutdown", int'(en), 0);
    pwr_a = 1'b1;
    cyc(8);
    chk("R12 stays off under shutdown", int'(en), 0);
    shdn = 1'b0;
    cyc(3);
    chk("R12 start after release", int'(en), 1);
    check_ramp();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule